// File: doc/BRIEF.md
# Event Time-Tag Counter Core

This block keeps a wall-clock time base and stamps four acquisition events with it. The time base has two parts. A seconds counter holds whole seconds. A coarse counter advances once per system clock tick; at 125 MHz one tick is 8 ns, so the absolute time is seconds plus coarse times 8 ns. When the coarse counter reaches the last tick of a second, it returns to zero and the seconds counter steps in the same edge.

Four one-cycle event strobes mark four events: trigger, acquisition start, acquisition stop and acquisition end. Each strobe freezes the current time into that event's own stamp and bumps that event's occurrence count. Software reaches the block over a plain single-cycle register bus. It can preset the seconds and coarse counters and read them back. Each event has its own four-word read window.

The fine word in every window exists for sub-tick interpolation. No interpolator is present, so that word always reads zero.

Top module: `evt_timetag`

## Requirements
- R1: After a synchronous reset, every stamp, every occurrence count and `bus_rdata` are zero, and both time counters restart from zero.
- R2: On each clock edge the coarse counter increases by one. When its value is at or above `TICKS_PER_SEC-1`, it becomes zero instead and the seconds counter increases by one on the same edge.
- R3: A bus write to word 0 (byte address 0x00) loads `bus_wdata` into the seconds counter on that edge, replacing any increment. A later read of word 0 returns the running seconds value.
- R4: A bus write to word 1 (byte address 0x04) loads `bus_wdata` into the coarse counter on that edge, replacing any increment. A later read of word 1 returns the running coarse value.
- R5: A high `evt_strobe[i]` on an edge captures the seconds and coarse values held just before that edge, both from the same edge. Bit 0 is trigger, bit 1 is acquisition start, bit 2 is acquisition stop and bit 3 is acquisition end. Event i has a window that starts at byte address 0x08 + 0x10*i.
- R6: Inside a window, the words are laid out as follows: +0x0 is the occurrence count, +0x4 is the captured seconds, +0x8 is the captured coarse value, and +0xC is the fine word, which always reads zero.
- R7: A stamp keeps its value until its own strobe fires again. A strobe of any other event leaves it unchanged.
- R8: Each capture increments that event's 32-bit occurrence count by exactly one.
- R9: `bus_rdata` takes the addressed word on the edge where `bus_rd` is high and holds it while `bus_rd` is low. Unmapped addresses read zero. Bus writes to any word other than 0 and 1 have no effect. Address bits [1:0] are ignored.
- R10: When several strobes are high on the same edge, all of the selected events capture the identical time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one coarse tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | N_EVT | One-cycle event strobes: bit 0 trigger, 1 start, 2 stop, 3 end |
| bus_wr | input | 1 | Single-cycle register write |
| bus_rd | input | 1 | Single-cycle register read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |

## Verification
The assertions assume that the event strobes are already synchronous to `clk`. A strobe held high is taken as a capture on every edge. The assertions also assume that a write address is meaningful only in the cycle where `bus_wr` is high. The stimulus drives every input half a cycle away from the active edge. It issues strobes as single cycles, and sometimes as several bits at once. It writes coarse values both below and above the wrap point, so that a preset past the last tick also exercises the wrap. A short second (`TICKS_PER_SEC` of 10) makes seconds rollovers frequent and lets them coincide with captures and presets.

// File: rtl/tt_pkg.sv
package tt_pkg;

  // Word indices of the two preset/readback counters.
  localparam int unsigned SEC_WORD       = 0;
  localparam int unsigned CRS_WORD       = 1;
  // First word of the first event window, and words per window.
  localparam int unsigned WIN_FIRST_WORD = 2;
  localparam int unsigned WIN_WORDS      = 4;

  typedef enum logic [1:0] {
    FLD_META = 2'd0,
    FLD_SEC  = 2'd1,
    FLD_CRS  = 2'd2,
    FLD_FINE = 2'd3
  } tag_field_e;

endpackage

// File: rtl/tt_timebase.sv
module tt_timebase #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_sec,
  input  logic              ld_crs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sec,
  output logic [DATA_W-1:0] crs
);

  localparam logic [DATA_W-1:0] LAST_TICK = DATA_W'(TICKS_PER_SEC - 1);

  logic at_last;
  assign at_last = (crs >= LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      crs <= '0;
    end else if (ld_crs) begin
      crs <= wdata;
    end else if (at_last) begin
      crs <= '0;
    end else begin
      crs <= crs + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec <= '0;
    end else if (ld_sec) begin
      sec <= wdata;
    end else if (at_last) begin
      sec <= sec + 1'b1;
    end
  end

endmodule

// File: rtl/tt_capture.sv
module tt_capture #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] sec_in,
  input  logic [DATA_W-1:0] crs_in,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] sec_q,
  output logic [DATA_W-1:0] crs_q
);

  // Seconds and coarse are taken on the same edge, so a stamp is never torn.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sec_q <= '0;
      crs_q <= '0;
    end else if (strobe) begin
      cnt   <= cnt + 1'b1;
      sec_q <= sec_in;
      crs_q <= crs_in;
    end
  end

endmodule

// File: rtl/tt_readmux.sv
module tt_readmux
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 6,
  parameter int unsigned N_EVT  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd,
  input  logic [WORD_W-1:0]            word,
  input  logic [DATA_W-1:0]            sec,
  input  logic [DATA_W-1:0]            crs,
  input  logic [N_EVT-1:0][DATA_W-1:0] cap_cnt,
  input  logic [N_EVT-1:0][DATA_W-1:0] cap_sec,
  input  logic [N_EVT-1:0][DATA_W-1:0] cap_crs,
  output logic [DATA_W-1:0]            rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    int rel;
    sel = '0;
    rel = 0;
    if (int'(word) == SEC_WORD) begin
      sel = sec;
    end else if (int'(word) == CRS_WORD) begin
      sel = crs;
    end else begin
      for (int i = 0; i < N_EVT; i++) begin
        rel = int'(word) - int'(WIN_FIRST_WORD) - int'(WIN_WORDS) * i;
        if (rel >= 0 && rel < int'(WIN_WORDS)) begin
          case (tag_field_e'(rel[1:0]))
            FLD_META: sel = cap_cnt[i];
            FLD_SEC:  sel = cap_sec[i];
            FLD_CRS:  sel = cap_crs[i];
            default:  sel = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= sel;
    end
  end

endmodule

// File: rtl/evt_timetag.sv
module evt_timetag
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned N_EVT         = 4,
  parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_strobe,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]            word;
  logic                         unused_lsb;
  logic                         ld_sec;
  logic                         ld_crs;
  logic [DATA_W-1:0]            tb_sec;
  logic [DATA_W-1:0]            tb_crs;
  logic [N_EVT-1:0][DATA_W-1:0] cap_cnt;
  logic [N_EVT-1:0][DATA_W-1:0] cap_sec;
  logic [N_EVT-1:0][DATA_W-1:0] cap_crs;

  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign ld_sec     = bus_wr && (word == WORD_W'(SEC_WORD));
  assign ld_crs     = bus_wr && (word == WORD_W'(CRS_WORD));

  tt_timebase #(
    .DATA_W        (DATA_W),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .ld_sec (ld_sec),
    .ld_crs (ld_crs),
    .wdata  (bus_wdata),
    .sec    (tb_sec),
    .crs    (tb_crs)
  );

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    tt_capture #(
      .DATA_W (DATA_W)
    ) u_cap (
      .clk    (clk),
      .rst    (rst),
      .strobe (evt_strobe[g]),
      .sec_in (tb_sec),
      .crs_in (tb_crs),
      .cnt    (cap_cnt[g]),
      .sec_q  (cap_sec[g]),
      .crs_q  (cap_crs[g])
    );
  end

  tt_readmux #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W),
    .N_EVT  (N_EVT)
  ) u_readmux (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .word    (word),
    .sec     (tb_sec),
    .crs     (tb_crs),
    .cap_cnt (cap_cnt),
    .cap_sec (cap_sec),
    .cap_crs (cap_crs),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned N_EVT         = 4,
  parameter int unsigned TICKS_PER_SEC = 125_000_000
) (
  input logic                         clk,
  input logic                         rst,
  input logic [N_EVT-1:0]             evt_strobe,
  input logic                         bus_rd,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic                         ld_sec,
  input logic                         ld_crs,
  input logic [DATA_W-1:0]            sec,
  input logic [DATA_W-1:0]            crs,
  input logic [N_EVT-1:0][DATA_W-1:0] cap_cnt,
  input logic [N_EVT-1:0][DATA_W-1:0] cap_sec,
  input logic [N_EVT-1:0][DATA_W-1:0] cap_crs
);

  localparam logic [DATA_W-1:0] LAST_TICK = DATA_W'(TICKS_PER_SEC - 1);

  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ld_crs && crs < LAST_TICK) |=> crs == $past(crs) + 1'b1); // R2
  AST_COARSE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!ld_crs && crs >= LAST_TICK) |=> crs == '0); // R2
  AST_SEC_ROLL: assert property (@(posedge clk) disable iff (rst)
    (!ld_sec && crs >= LAST_TICK) |=> sec == $past(sec) + 1'b1); // R2
  AST_SEC_STILL: assert property (@(posedge clk) disable iff (rst)
    (!ld_sec && crs < LAST_TICK) |=> $stable(sec)); // R2
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_sec |=> sec == $past(bus_wdata)); // R3
  AST_CRS_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_crs |=> crs == $past(bus_wdata)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9

  for (genvar g = 0; g < N_EVT; g++) begin : g_chk
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      evt_strobe[g] |=> (cap_sec[g] == $past(sec) && cap_crs[g] == $past(crs))); // R5
    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !evt_strobe[g] |=> ($stable(cap_sec[g]) && $stable(cap_crs[g]) && $stable(cap_cnt[g]))); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      evt_strobe[g] |=> cap_cnt[g] == $past(cap_cnt[g]) + 1'b1); // R8
  end

endmodule

bind evt_timetag tt_checker #(
  .DATA_W        (DATA_W),
  .N_EVT         (N_EVT),
  .TICKS_PER_SEC (TICKS_PER_SEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_strobe (evt_strobe),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_wdata  (bus_wdata),
  .ld_sec     (ld_sec),
  .ld_crs     (ld_crs),
  .sec        (tb_sec),
  .crs        (tb_crs),
  .cap_cnt    (cap_cnt),
  .cap_sec    (cap_sec),
  .cap_crs    (cap_crs)
);

// File: tb/evt_timetag_test.sv
`timescale 1ns/1ps
module evt_timetag_test;

  localparam int unsigned TICKS = 10;
  localparam int unsigned NE    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt_strobe = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always #2.5 clk = ~clk;

  evt_timetag #(
    .DATA_W (32), .ADDR_W (8), .N_EVT (NE), .TICKS_PER_SEC (TICKS)
  ) uut (
    .clk (clk), .rst (rst), .evt_strobe (evt_strobe),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  // Behavioural reference model
  logic [31:0] m_sec, m_crs, m_rdata;
  logic [31:0] m_cnt  [NE];
  logic [31:0] m_tsec [NE];
  logic [31:0] m_tcrs [NE];
  logic [7:0]  m_addr;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int w;
    int k;
    int f;
    w = int'(a) / 4;
    if (w == 0) return m_sec;
    if (w == 1) return m_crs;
    if (w < 2 || w >= 2 + 4 * NE) return 32'h0;
    k = (w - 2) / 4;
    f = (w - 2) % 4;
    if (f == 0) return m_cnt[k];
    if (f == 1) return m_tsec[k];
    if (f == 2) return m_tcrs[k];
    return 32'h0;
  endfunction

  function automatic string area_tag(input logic [7:0] a);
    int w;
    w = int'(a) / 4;
    if (w == 0) return "R3";
    if (w == 1) return "R4";
    if (w < 2 + 4 * NE) return "R5";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sec = 0; m_crs = 0; m_rdata = 0; m_addr = 0;
      for (int i = 0; i < NE; i++) begin
        m_cnt[i] = 0; m_tsec[i] = 0; m_tcrs[i] = 0;
      end
    end else begin
      bit wrap;
      int w;
      if (bus_rd) begin
        m_rdata = model_read(bus_addr);
        m_addr  = bus_addr;
      end
      for (int i = 0; i < NE; i++) begin
        if (evt_strobe[i]) begin
          m_cnt[i]  = m_cnt[i] + 1;
          m_tsec[i] = m_sec;
          m_tcrs[i] = m_crs;
        end
      end
      wrap = (m_crs >= TICKS - 1);
      w = int'(bus_addr) / 4;
      if (bus_wr && w == 1) m_crs = bus_wdata;
      else if (wrap)        m_crs = 0;
      else                  m_crs = m_crs + 1;
      if (bus_wr && w == 0) m_sec = bus_wdata;
      else if (wrap)        m_sec = m_sec + 1;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      n_vec++;
      if (bus_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL %s rdata per-cycle addr=%h actual=%h expected=%h",
                 area_tag(m_addr), m_addr, bus_rdata, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each operation occupies exactly one clock edge, starting at a negedge.
  task automatic op_wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic op_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic op_evt(input logic [NE-1:0] s);
    evt_strobe = s;
    @(negedge clk);
    evt_strobe = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    // R1: every tag word is zero after reset
    for (int a = 8; a < 8 + 16 * NE; a += 4) op_rd(8'(a), 32'h0, "R1 tag word");

    // R3/R4: presets and readback
    op_wr(8'h04, 32'd0);
    op_wr(8'h00, 32'd100);
    op_rd(8'h00, 32'd100, "R3 seconds readback");
    op_rd(8'h04, 32'd2,   "R4 coarse readback");

    // R2: rollover into seconds
    op_wr(8'h04, 32'd0);
    op_wr(8'h00, 32'd500);
    op_wr(8'h04, 32'd9);
    op_rd(8'h00, 32'd500, "R2 seconds before wrap");
    op_rd(8'h00, 32'd501, "R2 seconds after wrap");
    op_rd(8'h04, 32'd1,   "R2 coarse after wrap");
    // R2: preset above the last tick wraps at once
    op_wr(8'h04, 32'd40);
    op_rd(8'h00, 32'd501, "R2 seconds at over-range preset");
    op_rd(8'h00, 32'd502, "R2 seconds after over-range wrap");

    // R5/R6: trigger stamp and window layout
    op_wr(8'h04, 32'd0);
    op_wr(8'h00, 32'd200);
    op_evt(4'b0001);
    op_rd(8'h08, 32'd1,   "R8 trigger count");
    op_rd(8'h0C, 32'd200, "R5 trigger seconds");
    op_rd(8'h10, 32'd1,   "R5 trigger coarse");
    op_rd(8'h14, 32'd0,   "R6 trigger fine");

    // R10/R7/R8: simultaneous capture, then one event refreshed
    op_wr(8'h04, 32'd0);
    op_wr(8'h00, 32'd300);
    op_evt(4'b1111);
    op_evt(4'b0010);
    op_rd(8'h08, 32'd2,   "R8 trigger count twice");
    op_rd(8'h10, 32'd1,   "R10 trigger coarse");
    op_rd(8'h30, 32'd1,   "R10 stop coarse");
    op_rd(8'h20, 32'd2,   "R7 start coarse refreshed");
    op_rd(8'h2C, 32'd300, "R7 stop seconds");
    op_rd(8'h0C, 32'd300, "R7 trigger seconds");
    op_rd(8'h38, 32'd1,   "R8 end count");
    op_rd(8'h44, 32'd0,   "R6 end fine");

    // R9: ignored writes, unmapped reads, hold
    op_wr(8'h08, 32'hDEAD_BEEF);
    op_wr(8'h44, 32'h1234_5678);
    op_rd(8'h08, 32'd2,   "R9 write to count ignored");
    op_rd(8'h44, 32'd0,   "R9 write to fine ignored");
    op_rd(8'h48, 32'd0,   "R9 unmapped read");
    op_rd(8'hFC, 32'd0,   "R9 unmapped top read");
    op_rd(8'h0E, 32'd300, "R9 low address bits ignored");
    held = bus_rdata;
    repeat (5) @(negedge clk);
    chk("R9 rdata held while idle", bus_rdata, held);

    // Mixed traffic, checked every cycle against the model
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < NE; i++) evt_strobe[i] = ($urandom % 5 == 0);
      bus_rd   = ($urandom % 2 == 0);
      bus_addr = ($urandom % 12 == 0) ? 8'(($urandom % 4) * 4 + 8'h48)
                                      : 8'(($urandom % 18) * 4);
      bus_wr   = ($urandom % 10 == 0);
      bus_wdata = ($urandom % 2 == 0) ? 32'($urandom % 14) : $urandom;
      if (bus_wr && ($urandom % 2 == 0)) bus_addr = 8'(($urandom % 2) * 4);
      @(negedge clk);
    end
    evt_strobe = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule